// File: doc/BRIEF.md
# Serial Byte Receiver with Request/Acknowledge Delivery

The block receives asynchronous serial characters on a single idle-high line. A falling edge on the line is taken as the start of a frame. The line is checked again half a bit period later to reject glitches. After that, the block samples each following bit at the middle of its period. A frame carries eight data bits, least-significant bit first, then one parity bit, then one high stop bit.

When the stop bit has been sampled, the block presents the byte together with a parity-error flag and raises a ready request. The request stays high until the consumer asserts the acknowledge. The consumer may tie the acknowledge directly to the request. The sender is assumed not to begin a new frame before the handshake completes, so the block holds only one byte.

Clock frequency and baud rate are parameters, and the bit-period and half-period counts are derived from them. The serial input passes through a two-flop synchronizer before any logic uses it.

Top module: `uart_rx_hs`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle, and after that edge `byte_ready`, `data_out` and `parity_err` are all 0.
- R2: The first data bit after the start bit is stored in `data_out[0]` and the eighth in `data_out[7]`.
- R3: When `odd_sel` is 0 (even parity), `parity_err` is 1 exactly when the XOR of the 8 data bits and the parity bit is 1.
- R4: When `odd_sel` is 1 (odd parity), `parity_err` is 1 exactly when the XOR of the 8 data bits and the parity bit is 0.
- R5: Once `byte_ready` rises, it stays high while `byte_taken` is low, and `data_out` and `parity_err` hold their values throughout.
- R6: A cycle in which `byte_ready` and `byte_taken` are both high is followed by `byte_ready` low. This lets `byte_taken` be wired to `byte_ready`, and the byte is still delivered.
- R7: If the line returns high before the half-bit recheck, no byte is reported, and the next proper frame is received correctly.
- R8: `byte_ready` rises between 10 and 11 bit periods after the falling edge of the start bit, which places it inside the stop bit.
- R9: No more than 9 bits (8 data and 1 parity) are shifted in per frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_serial | input | 1 | Asynchronous serial line, idle high |
| odd_sel | input | 1 | 1 selects odd parity, 0 selects even parity |
| data_out | output | 8 | Last received byte |
| parity_err | output | 1 | Parity mismatch on the last received byte |
| byte_ready | output | 1 | Request: a byte is waiting to be taken |
| byte_taken | input | 1 | Acknowledge from the consumer |

## Verification
Two situations are the hardest to reach from the ports.

The first is the glitch path: a low pulse that ends before the half-bit recheck. The stimulus drives the line low for only three clock cycles, well short of half a period. It then waits more than a full frame time to confirm that no request appears, and follows with a real frame to show that reception recovers.

The second is the delayed handshake, where the request must hold and the outputs must not change. To reach it, the bench withholds the acknowledge for several cycles after every table-driven frame. Separately, it runs the looped-back configuration, where the request is acknowledged at once and is high for exactly one cycle.

// File: rtl/uart_rx_hs_pkg.sv
// Shared types for the serial byte receiver.
package uart_rx_hs_pkg;
    // Control states of the receive sequencer.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_BITS  = 3'd2,
        ST_STOP  = 3'd3,
        ST_HAND  = 3'd4
    } rx_state_t;

    localparam int FRAME_BITS = 9;   // 8 data bits plus 1 parity bit
endpackage

// File: rtl/rx_sync.sv
// Two-flop synchronizer for the asynchronous serial line.
// Assumes the line idles high; the reset value matches idle, so reset
// cannot be mistaken for a start edge.
module rx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta;

    // Pass the raw line through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b1;
            dout <= 1'b1;
        end else begin
            meta <= din;
            dout <= meta;
        end
    end
endmodule

// File: rtl/rx_bit_timer.sv
// Bit-period timer. Counts clock cycles from a restart.
// Pulses half_tick at cycle HALF-1 and full_tick at cycle FULL-1,
// then wraps to zero. Assumes FULL >= 2.
module rx_bit_timer #(
    parameter int FULL = 5208,
    parameter int HALF = 2604
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic half_tick,
    output logic full_tick
);
    localparam int CW = (FULL > 1) ? $clog2(FULL) : 1;
    localparam logic [CW-1:0] FULL_M1 = CW'(FULL - 1);
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    assign half_tick = (cnt == HALF_M1);
    assign full_tick = (cnt == FULL_M1);

    // Advance the cycle count, wrapping at the end of a bit period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || full_tick) cnt <= '0;
        else                                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/rx_bit_counter.sv
// Counts the bits sampled in the current frame and flags the last one.
// Assumes inc is only asserted for bits belonging to the frame.
module rx_bit_counter #(
    parameter int NBITS = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);
    localparam int CW = $clog2(NBITS + 1);
    localparam logic [CW-1:0] LAST_IDX = CW'(NBITS - 1);

    logic [CW-1:0] count;

    assign last = (count == LAST_IDX);

    // Count sampled bits; clear at the start of each frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) count <= '0;
        else if (inc)        count <= count + 1'b1;
    end

    // At most NBITS samples per frame (9 = 8 data + parity).
    p_bit_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(NBITS));
endmodule

// File: rtl/uart_rx_hs.sv
// Serial byte receiver with request/acknowledge delivery.
// Frame: start (low), 8 data bits LSB first, parity, stop (high).
// Assumes the sender waits for the handshake to finish before the next start bit.
module uart_rx_hs
    import uart_rx_hs_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000,
    parameter int BAUD   = 19_200
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_serial,
    input  logic       odd_sel,
    output logic [7:0] data_out,
    output logic       parity_err,
    output logic       byte_ready,
    input  logic       byte_taken
);
    localparam int BIT_CYC  = CLK_HZ / BAUD;
    localparam int HALF_CYC = BIT_CYC / 2;

    rx_state_t              state;
    logic                   line, line_q;
    logic                   half_tick, full_tick, last_bit;
    logic                   tmr_restart, cnt_clear, cnt_inc;
    logic [FRAME_BITS-1:0]  shreg;

    rx_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_serial),
        .dout  (line)
    );

    rx_bit_timer #(.FULL(BIT_CYC), .HALF(HALF_CYC)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (tmr_restart),
        .half_tick (half_tick),
        .full_tick (full_tick)
    );

    rx_bit_counter #(.NBITS(FRAME_BITS)) u_bitcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .last  (last_bit)
    );

    // Timer and counter control derived from the current state.
    always_comb begin
        tmr_restart = (state == ST_IDLE) || (state == ST_START && half_tick);
        cnt_clear   = (state == ST_IDLE);
        cnt_inc     = (state == ST_BITS) && full_tick;
    end

    // Delayed copy of the synchronized line, for start-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= 1'b1;
        else        line_q <= line;
    end

    // Shift sampled bits in LSB first at each mid-bit tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       shreg <= '0;
        else if (cnt_inc) shreg <= {line, shreg[FRAME_BITS-1:1]};
    end

    // Receive sequencer: start detect, glitch reject, bit collection, handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (line_q && !line)         state <= ST_START;
                ST_START: if (half_tick)               state <= line ? ST_IDLE : ST_BITS;
                ST_BITS:  if (full_tick && last_bit)   state <= ST_STOP;
                ST_STOP:  if (full_tick)               state <= ST_HAND;
                ST_HAND:  if (byte_taken)              state <= ST_IDLE;
                default:                               state <= ST_IDLE;
            endcase
        end
    end

    // Capture the byte and the parity verdict at the middle of the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out   <= '0;
            parity_err <= 1'b0;
            byte_ready <= 1'b0;
        end else if (state == ST_STOP && full_tick) begin
            data_out   <= shreg[7:0];
            parity_err <= (^shreg) ^ odd_sel;
            byte_ready <= 1'b1;
        end else if (state == ST_HAND && byte_taken) begin
            byte_ready <= 1'b0;
        end
    end

    // R5: the request holds until it is acknowledged.
    p_ready_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready && !byte_taken |=> byte_ready);

    // R5: the byte and flag do not change while waiting for the acknowledge.
    p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready && !byte_taken |=> $stable(data_out) && $stable(parity_err));

    // R6: an acknowledged request drops on the next cycle.
    p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready && byte_taken |=> !byte_ready);

    // R7: a new request can appear only after the sequencer has passed through the stop state.
    p_ready_after_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_ready) |-> $past(state) == ST_STOP);
endmodule

// File: tb/uart_rx_hs_tb.sv
// Bench for uart_rx_hs: a table of frames walked by one loop, then directed
// tests for reset, glitch rejection and a looped-back acknowledge.
module uart_rx_hs_tb;
    localparam int CLK_HZ = 100_000_000;
    localparam int BAUD   = 10_000_000;
    localparam int BIT    = CLK_HZ / BAUD;   // 10 cycles per bit
    localparam int NVEC   = 8;

    // Vector fields: {odd_sel, corrupt_parity, data[7:0]}
    localparam logic [9:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h55},
        {1'b0, 1'b0, 8'hA3},
        {1'b1, 1'b0, 8'h00},
        {1'b1, 1'b0, 8'hFF},
        {1'b0, 1'b1, 8'h81},
        {1'b1, 1'b1, 8'h3C},
        {1'b0, 1'b1, 8'h00},
        {1'b1, 1'b0, 8'h7E}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_serial = 1'b1;
    logic       odd_sel = 1'b0;
    logic       ack_drv = 1'b0;
    logic       tie_mode = 1'b0;
    logic [7:0] data_out;
    logic       parity_err, byte_ready, byte_taken;
    int         checks = 0, errors = 0, cyc = 0;

    assign byte_taken = tie_mode ? byte_ready : ack_drv;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    uart_rx_hs #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_serial  (rx_serial),
        .odd_sel    (odd_sel),
        .data_out   (data_out),
        .parity_err (parity_err),
        .byte_ready (byte_ready),
        .byte_taken (byte_taken)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive start, 8 data bits LSB first and parity; leave the line high (stop).
    task automatic send_frame(input logic [7:0] d, input logic p, output int t0);
        @(negedge clk);
        rx_serial = 1'b0;
        t0 = cyc;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_serial = d[i];
            repeat (BIT) @(negedge clk);
        end
        rx_serial = p;
        repeat (BIT) @(negedge clk);
        rx_serial = 1'b1;
    endtask

    // Wait on the falling clock edge for the request; return the cycle it was seen.
    task automatic wait_ready(output int t1, output bit ok);
        ok = 0;
        t1 = 0;
        for (int k = 0; k < 3 * BIT; k++) begin
            if (byte_ready) begin
                ok = 1;
                t1 = cyc;
                break;
            end
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int t0, t1, lat;
        bit ok;
        logic [7:0] d;
        logic p, flip, o;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 ready", byte_ready, 0);
        check("R1 data", data_out, 0);
        check("R1 perr", parity_err, 0);
        rst_n = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        check("R1 idle after reset", byte_ready, 0);

        // Table-driven frames with a delayed acknowledge.
        for (int v = 0; v < NVEC; v++) begin
            o = VEC[v][9];
            flip = VEC[v][8];
            d = VEC[v][7:0];
            odd_sel = o;
            p = (^d) ^ o ^ flip;
            send_frame(d, p, t0);
            wait_ready(t1, ok);
            check("R8 ready seen", ok, 1);
            lat = t1 - t0;
            check("R8 latency window", (lat >= 10 * BIT && lat <= 11 * BIT), 1);
            check("R2 data", data_out, d);
            check(o ? "R4 odd parity" : "R3 even parity", parity_err, flip);
            // R5: hold the acknowledge off for a few cycles.
            repeat (4) @(negedge clk);
            check("R5 ready held", byte_ready, 1);
            check("R5 data stable", data_out, d);
            check("R5 perr stable", parity_err, flip);
            ack_drv = 1'b1;
            @(negedge clk);
            ack_drv = 1'b0;
            check("R6 ready dropped", byte_ready, 0);
            repeat (2 * BIT) @(negedge clk);
        end

        // R7: short low glitch must not start a frame.
        odd_sel = 1'b0;
        @(negedge clk);
        rx_serial = 1'b0;
        repeat (3) @(negedge clk);
        rx_serial = 1'b1;
        ok = 0;
        for (int k = 0; k < 12 * BIT; k++) begin
            @(negedge clk);
            if (byte_ready) ok = 1;
        end
        check("R7 glitch ignored", ok, 0);
        send_frame(8'hC5, ^8'hC5, t0);
        wait_ready(t1, ok);
        check("R7 recovery ready", ok, 1);
        check("R7 recovery data", data_out, 8'hC5);
        ack_drv = 1'b1;
        @(negedge clk);
        ack_drv = 1'b0;
        repeat (2 * BIT) @(negedge clk);

        // R6: acknowledge tied back to the request.
        tie_mode = 1'b1;
        odd_sel = 1'b1;
        send_frame(8'h96, ~(^8'h96), t0);
        wait_ready(t1, ok);
        check("R6 tied ready", ok, 1);
        check("R6 tied data", data_out, 8'h96);
        check("R6 tied perr", parity_err, 0);
        @(negedge clk);
        check("R6 tied one cycle", byte_ready, 0);
        repeat (2 * BIT) @(negedge clk);
        tie_mode = 1'b0;

        // R1: reset in the middle of a pending request.
        odd_sel = 1'b0;
        send_frame(8'h5A, 1'b1, t0);
        wait_ready(t1, ok);
        check("R3 even error before reset", parity_err, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset clears ready", byte_ready, 0);
        check("R1 reset clears perr", parity_err, 0);
        check("R1 reset clears data", data_out, 0);
        rst_n = 1'b1;
        repeat (2 * BIT) @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule